// File: doc/BRIEF.md
# Paired Byte-to-Word Write Controller

This block sits between a source that issues byte-wide table writes and an external 16-bit word-wide memory reached over a multiplexed address/data bus. Each request carries a byte address and one data byte. Writes to even byte addresses are held inside the block. A write to the odd byte address of the same word then issues a single 16-bit word write. The new byte goes to the upper half of the bus and the held byte goes to the lower half, with both byte selects active.

Every request, even or odd, runs one bus cycle through four named states after `ST_IDLE`. In `ST_ADDR` the word address (byte address shifted right by one) is driven with address-latch-enable high. In `ST_LATCH` the address-latch-enable falls while the address is still driven. `ST_DATA` lasts `WR_PHASE_CYC` cycles with chip enable low. In it an odd write drives the word and pulses the high write strobe, and an even write leaves the bus released. `ST_RECOV` raises the strobes again. The transitions are: `ST_IDLE`→`ST_ADDR` on an accepted request, `ST_ADDR`→`ST_LATCH` and `ST_LATCH`→`ST_DATA` unconditionally, `ST_DATA`→`ST_RECOV` when the phase timer expires, and `ST_RECOV`→`ST_IDLE`. A correct word needs the even write first and then the odd write of the same word.

Top module: `wordpair_wr_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `ale` is 0, `ad_oe` is 0, `ba0` is 0, and every active-low strobe (`ce_n`, `oe_n`, `wrh_n`, `wrl_n`, `ub_n`, `lb_n`) is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly 3 + `WR_PHASE_CYC` cycles and returns to 1 afterwards.
- R3: In the first cycle after acceptance, `ale`=1, `ad_oe`=1 and `ad_out` equals bits 16:1 of the byte address. In the second cycle, `ale`=0 and the same address is still driven with `ad_oe`=1.
- R4: When `WIDE_ADDR`=1, `addr_hi` carries bits 20:17 of the byte address during the two address cycles and is 0 otherwise. When `WIDE_ADDR`=0, it is always 0.
- R5: From the first address cycle onward, `ba0` equals bit 0 of the accepted byte address.
- R6: For an even write (address bit 0 = 0), every data-phase cycle has `ce_n`=0, `ad_oe`=0 and `wrh_n`=1, and the data byte is stored in the holding latch.
- R7: For an odd write, each of the `WR_PHASE_CYC` data-phase cycles has `ce_n`=0, `wrh_n`=0, `ad_oe`=1 and `ad_out` = {new byte in bits 15:8, held byte in bits 7:0}.
- R8: `ub_n` and `lb_n` are 0 exactly in the cycles where `ce_n` is 0.
- R9: `wrl_n` and `oe_n` stay 1 at all times.
- R10: The holding latch changes only on even writes. Odd writes leave it unchanged, and a later even write replaces it.
- R11: While `req_ready` is 0, `req_valid` has no effect: no further bus cycle starts from it.
- R12: The cycle after the data phase has `ce_n`=1, `wrh_n`=1 and `ale`=0. An odd write keeps the word on `ad_out` with `ad_oe`=1, and an even write keeps `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | BYTE_ADDR_W (21) | Byte address of the write |
| req_data | input | 8 | Data byte of the write |
| ad_out | output | 16 | Multiplexed address/data value |
| ad_oe | output | 1 | 1 drives `ad_out` onto the bus, 0 releases it |
| addr_hi | output | HI_BITS (4) | Upper word-address lines |
| ale | output | 1 | Address latch enable, active high |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low, held inactive |
| wrh_n | output | 1 | High write strobe, active low |
| wrl_n | output | 1 | Low write strobe, active low, held inactive |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |
| ba0 | output | 1 | Bit 0 of the current byte address |

## Verification
Once a request is taken on a rising edge, the address phase appears in the following cycle. The latch phase comes one cycle later, the `WR_PHASE_CYC` data cycles follow, then the recovery cycle, and `req_ready` rises 3 + `WR_PHASE_CYC` cycles after acceptance. The driver queues one expected bus cycle per request. The monitor samples on falling edges and, when it sees `ale` high, pops that entry and steps through the phases one falling edge at a time. In this way each output is compared in the exact cycle where it is due. An `ale` seen with nothing queued means a request was wrongly taken while busy.

// File: rtl/wpw_pkg.sv
package wpw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_DATA,
        ST_RECOV
    } wpw_state_e;
endpackage

// File: rtl/wpw_phase_timer.sv
module wpw_phase_timer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] START = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/wpw_hold_latch.sv
module wpw_hold_latch #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/wpw_sequencer.sv
module wpw_sequencer
    import wpw_pkg::*;
#(
    parameter int unsigned LO_BITS     = 16,
    parameter int unsigned HI_BITS     = 4,
    parameter bit          WIDE_ADDR   = 1'b1,
    parameter int unsigned BYTE_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [LO_BITS+HI_BITS:0] req_addr,
    input  logic [BYTE_W-1:0]      req_data,
    output logic                   req_ready,
    input  logic [BYTE_W-1:0]      hold_byte,
    output logic                   hold_load,
    output logic                   tmr_load,
    output logic                   tmr_run,
    input  logic                   tmr_done,
    output logic [LO_BITS-1:0]     ad_out,
    output logic                   ad_oe,
    output logic [HI_BITS-1:0]     addr_hi,
    output logic                   ale,
    output logic                   ce_n,
    output logic                   wrh_n,
    output logic                   ub_n,
    output logic                   lb_n,
    output logic                   ba0
);
    localparam int unsigned BYTE_ADDR_W = LO_BITS + HI_BITS + 1;

    wpw_state_e state, state_nx;
    logic [BYTE_ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0]      cur_data;
    logic                   accept;
    logic                   odd;
    logic [LO_BITS-1:0]     word_lo;
    logic [HI_BITS-1:0]     word_hi;
    logic [LO_BITS-1:0]     word_data;

    assign accept    = req_valid && (state == ST_IDLE);
    assign hold_load = accept && !req_addr[0];
    assign odd       = cur_addr[0];
    assign word_lo   = cur_addr[LO_BITS:1];
    assign word_data = {cur_data, hold_byte};
    assign ba0       = cur_addr[0];

    generate
        if (WIDE_ADDR) begin : g_wide
            assign word_hi = cur_addr[BYTE_ADDR_W-1:LO_BITS+1];
        end else begin : g_narrow
            assign word_hi = '0;
        end
    endgenerate

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            cur_data <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur_addr <= req_addr;
                cur_data <= req_data;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_DATA;
            ST_DATA:  if (tmr_done) state_nx = ST_RECOV;
            ST_RECOV: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        ad_out    = '0;
        ad_oe     = 1'b0;
        addr_hi   = '0;
        ale       = 1'b0;
        ce_n      = 1'b1;
        wrh_n     = 1'b1;
        ub_n      = 1'b1;
        lb_n      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ADDR: begin
                ale     = 1'b1;
                ad_oe   = 1'b1;
                ad_out  = word_lo;
                addr_hi = word_hi;
            end
            ST_LATCH: begin
                ad_oe    = 1'b1;
                ad_out   = word_lo;
                addr_hi  = word_hi;
                tmr_load = 1'b1;
            end
            ST_DATA: begin
                tmr_run = 1'b1;
                ce_n    = 1'b0;
                ub_n    = 1'b0;
                lb_n    = 1'b0;
                if (odd) begin
                    ad_oe  = 1'b1;
                    ad_out = word_data;
                    wrh_n  = 1'b0;
                end
            end
            ST_RECOV: begin
                if (odd) begin
                    ad_oe  = 1'b1;
                    ad_out = word_data;
                end
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wordpair_wr_ctrl.sv
module wordpair_wr_ctrl #(
    parameter int unsigned LO_BITS      = 16,
    parameter int unsigned HI_BITS      = 4,
    parameter bit          WIDE_ADDR    = 1'b1,
    parameter int unsigned WR_PHASE_CYC = 2,
    localparam int unsigned BYTE_ADDR_W = LO_BITS + HI_BITS + 1,
    localparam int unsigned BYTE_W      = LO_BITS / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [BYTE_ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0]      req_data,
    output logic [LO_BITS-1:0]     ad_out,
    output logic                   ad_oe,
    output logic [HI_BITS-1:0]     addr_hi,
    output logic                   ale,
    output logic                   ce_n,
    output logic                   oe_n,
    output logic                   wrh_n,
    output logic                   wrl_n,
    output logic                   ub_n,
    output logic                   lb_n,
    output logic                   ba0
);
    logic              hold_load;
    logic [BYTE_W-1:0] hold_byte;
    logic              tmr_load;
    logic              tmr_run;
    logic              tmr_done;

    assign oe_n  = 1'b1;
    assign wrl_n = 1'b1;

    wpw_hold_latch #(.BYTE_W(BYTE_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (hold_load),
        .din  (req_data),
        .dout (hold_byte)
    );

    wpw_phase_timer #(.CYCLES(WR_PHASE_CYC)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .run  (tmr_run),
        .done (tmr_done)
    );

    wpw_sequencer #(
        .LO_BITS  (LO_BITS),
        .HI_BITS  (HI_BITS),
        .WIDE_ADDR(WIDE_ADDR),
        .BYTE_W   (BYTE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_data (req_data),
        .req_ready(req_ready),
        .hold_byte(hold_byte),
        .hold_load(hold_load),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .tmr_done (tmr_done),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .addr_hi  (addr_hi),
        .ale      (ale),
        .ce_n     (ce_n),
        .wrh_n    (wrh_n),
        .ub_n     (ub_n),
        .lb_n     (lb_n),
        .ba0      (ba0)
    );
endmodule

// File: rtl/wpw_checker.sv
module wpw_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ad_oe,
    input logic ale,
    input logic ce_n,
    input logic oe_n,
    input logic wrh_n,
    input logic wrl_n,
    input logic ub_n,
    input logic lb_n,
    input logic ba0
);
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ale_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ale);

    p_ale_falls_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && ad_oe && ce_n));

    p_even_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ba0) |-> (!ad_oe && wrh_n));

    p_odd_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ba0) |-> (!wrh_n && ad_oe));

    p_wrh_inside_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrh_n |-> !ce_n);

    p_selects_track_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ub_n == ce_n) && (lb_n == ce_n));

    p_unused_strobes_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrl_n && oe_n);

    p_no_ale_in_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !ale);

    p_recovery_after_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> (wrh_n && !ale && !req_ready));
endmodule

bind wordpair_wr_ctrl wpw_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .ad_oe    (ad_oe),
    .ale      (ale),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .wrh_n    (wrh_n),
    .wrl_n    (wrl_n),
    .ub_n     (ub_n),
    .lb_n     (lb_n),
    .ba0      (ba0)
);

// File: tb/sim_wordpair_wr_ctrl.sv
`timescale 1ns/1ps
module sim_wordpair_wr_ctrl;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  addr_hi;
    logic        ale, ce_n, oe_n, wrh_n, wrl_n, ub_n, lb_n, ba0;

    typedef struct packed {
        logic [20:0] addr;
        logic [15:0] word;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    logic [7:0] hold_model = 8'h00;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    wordpair_wr_ctrl #(.WR_PHASE_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .ale(ale), .ce_n(ce_n), .oe_n(oe_n), .wrh_n(wrh_n),
        .wrl_n(wrl_n), .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // driver: issues one write, optionally pokes req_valid while busy
    task automatic wr(input logic [20:0] a, input logic [7:0] d, input bit poke_busy);
        exp_t e;
        int   busy;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (!a[0]) hold_model = d;
        e.addr = a;
        e.word = {d, hold_model};
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        busy = 0;
        if (poke_busy) begin
            // R11: keep req_valid high with other data during the busy window
            req_addr = a ^ 21'h00_0102;
            req_data = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready) begin
            busy++;
            if (poke_busy && busy == 3 + W - 1) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(busy == 3 + W, "R2 ready low cycles", busy, 3 + W);
    endtask

    // monitor: pops expected bus cycles and walks the phases
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(wrl_n && oe_n, "R9 wrl_n/oe_n high", {wrl_n, oe_n}, 2'b11);
                if (ale) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11 unexpected bus cycle", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(ad_oe && ad_out == e.addr[16:1], "R3 address phase", ad_out, e.addr[16:1]);
                        chk(addr_hi == e.addr[20:17], "R4 upper lines", addr_hi, e.addr[20:17]);
                        chk(ba0 == e.addr[0], "R5 ba0", ba0, e.addr[0]);
                        chk(ce_n && wrh_n, "R3 no strobe in address phase", {ce_n, wrh_n}, 2'b11);
                        @(negedge clk);
                        chk(!ale && ad_oe && ad_out == e.addr[16:1], "R3 latch phase", {ale, ad_oe, ad_out}, {2'b01, e.addr[16:1]});
                        chk(addr_hi == e.addr[20:17], "R4 upper lines latch", addr_hi, e.addr[20:17]);
                        for (int i = 0; i < W; i++) begin
                            @(negedge clk);
                            chk(!ce_n, "R6/R7 ce_n in data", ce_n, 0);
                            chk(!ub_n && !lb_n, "R8 byte selects", {ub_n, lb_n}, 2'b00);
                            chk(addr_hi == 4'h0, "R4 upper lines idle in data", addr_hi, 0);
                            chk(ba0 == e.addr[0], "R5 ba0 data", ba0, e.addr[0]);
                            if (e.addr[0]) begin
                                chk(!wrh_n && ad_oe, "R7 strobe and drive", {wrh_n, ad_oe}, 2'b01);
                                chk(ad_out == e.word, "R7 R10 word value", ad_out, e.word);
                            end else begin
                                chk(wrh_n && !ad_oe, "R6 even released", {wrh_n, ad_oe}, 2'b10);
                            end
                        end
                        @(negedge clk);
                        chk(ce_n && wrh_n && !ale, "R12 recovery strobes", {ce_n, wrh_n, ale}, 3'b110);
                        chk(ub_n && lb_n, "R8 selects off", {ub_n, lb_n}, 2'b11);
                        chk(ad_oe == e.addr[0], "R12 recovery drive", ad_oe, e.addr[0]);
                        if (e.addr[0]) chk(ad_out == e.word, "R12 word held", ad_out, e.word);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(req_ready && !ale && !ad_oe && !ba0, "R1 reset ready/ale/oe/ba0",
            {req_ready, ale, ad_oe, ba0}, 4'b1000);
        chk(ce_n && oe_n && wrh_n && wrl_n && ub_n && lb_n, "R1 reset strobes high",
            {ce_n, oe_n, wrh_n, wrl_n, ub_n, lb_n}, 6'h3f);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        wr(21'h0000A4, 8'h5A, 1'b0);   // even then odd: word C35A
        wr(21'h0000A5, 8'hC3, 1'b0);
        wr(21'h1F2468, 8'h11, 1'b0);   // high address bits
        wr(21'h1F2469, 8'h22, 1'b0);
        wr(21'h1F2469, 8'h77, 1'b0);   // R10: odd again keeps held 11
        wr(21'h003330, 8'hA1, 1'b1);   // R11: valid held during busy
        repeat (6) @(negedge clk);     // any stray cycle hits the monitor
        wr(21'h003331, 8'hB2, 1'b0);   // low byte A1, not the poked value
        wr(21'h000010, 8'h01, 1'b0);   // R10: two evens, last one wins
        wr(21'h000012, 8'h02, 1'b0);
        wr(21'h000013, 8'hEE, 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all cycles seen", exp_q.size(), 0);
        chk(req_ready && ce_n && !ad_oe, "R1 idle after traffic", {req_ready, ce_n, ad_oe}, 3'b110);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule